// File: doc/BRIEF.md
# Cell Transmit Output Port with Byte and Nibble Lanes

This block empties one cell queue onto a transmit-side cell interface of the first UTOPIA level. The receiver raises a cell-available input when it can take a whole cell. The port then sends that cell with a start-of-cell flag on its first transfer. Each 9-bit queue entry leaves either as one full word or as two 4-bit nibbles. In nibble mode the ninth bit rides on a side line during both halves.

The port runs in one of two roles. As a master it owns an active-low enable output. It sends the whole programmed cell length on back-to-back cycles, and in nibble mode it also raises data line 7 so that a companion slave device is enabled with it. As a slave it follows an external active-low enable and steps to the next transfer unit only on clock edges where that enable is low. The queue in front of the port shows its head entry at all times, and it reports whether at least one complete cell is stored. The cell length, the byte/nibble select and the role are sampled when a cell starts.

Top module: `cell_out_port`

## Requirements
- R1: While reset is asserted and after reset, until a cell starts, `enb_n_out` is 1, and `soc`, `dout` and `q_rd_en` are 0.
- R2: A cell starts only on a clock edge where the port is idle and both `dn_clav` and `q_cell_ready` are 1. Its first transfer appears in the cycle after that edge.
- R3: In master role `enb_n_out` is 0 in every transfer cycle, and a cell's transfers occupy consecutive cycles with no gap. There are `cfg_cell_len` transfers in byte mode and twice that many in nibble mode.
- R4: `soc` is 1 only while the first transfer unit of a cell is presented (the whole first word in byte mode, its low nibble in nibble mode). It is 0 for every later transfer of the cell.
- R5: In byte mode (`cfg_byte_mode`=1) `dout[8:0]` carries the queue word unchanged, and each transfer pops exactly one word.
- R6: In nibble mode (`cfg_byte_mode`=0) a word is sent as bits 3:0 and then bits 7:4 on `dout[3:0]`. `dout[8]` holds the word's bit 8 during both halves, `dout[6:4]` are 0, and the queue is popped only on the high-nibble transfer.
- R7: In master nibble mode `dout[7]` is 1 in every transfer cycle, which enables a slave device.
- R8: In slave role (`cfg_master`=0) `enb_n_out` stays 1. The port steps to the next unit on an edge where `enb_n_in` is 0, and it holds `dout`, `soc` and the queue while `enb_n_in` is 1. In slave nibble mode `dout[7:4]` are 0.
- R9: After the last transfer of a cell at least one idle cycle follows (`enb_n_out`=1 in master role), and `dn_clav` is sampled again before the next cell starts.
- R10: Length, byte/nibble select and role are taken when a cell starts. Changing them in the middle of a cell has no effect on that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_byte_mode | input | 1 | 1: 9-bit word transfers, 0: nibble transfers |
| cfg_master | input | 1 | 1: master role driving the enable, 0: slave role |
| cfg_cell_len | input | 8 | Cell length in queue words (1 or more) |
| q_cell_ready | input | 1 | Queue holds at least one complete cell |
| q_rd_data | input | 9 | Head entry of the queue (show-ahead) |
| q_rd_en | output | 1 | Pop the head entry at this clock edge |
| dn_clav | input | 1 | Downstream can accept a cell |
| enb_n_in | input | 1 | External active-low enable in slave role |
| enb_n_out | output | 1 | Active-low enable driven in master role |
| soc | output | 1 | Start-of-cell flag |
| dout | output | 9 | Output data lines |

## Verification
On every cycle the assertions check the following: a cell starts only after cell-available and cell-ready both held, a master cell never pauses, the port falls idle after its last unit, a slave holds its position while its enable is high, and start-of-cell clears after the first unit. They also check that the side bit stays fixed across a word's two nibbles. The bench scenarios show the rest. These are the exact word and nibble order against the queue contents, the count of transfers per cell, the suppression of a start while the queue holds only part of a cell, and the fact that configuration changes made mid-cell are ignored.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int WORD_W = 9;
  localparam int NIB_W  = 4;
  localparam int LEN_W  = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } cop_state_e;
endpackage

// File: rtl/cop_rst_sync.sv
module cop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cop_seq.sv
module cop_seq
  import cop_pkg::*;
#(
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  input  logic          cfg_byte_mode,
  input  logic          cfg_master,
  input  logic [LW-1:0] cfg_cell_len,
  input  logic          enb_n_in,
  output logic          active,
  output logic          first_unit,
  output logic          hi_phase,
  output logic          byte_mode,
  output logic          master,
  output logic          pop
);
  cop_state_e    state_q, state_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] len_q;
  logic          phase_q, phase_d;
  logic          byte_q, master_q;
  logic          load_cfg;
  logic          advance;
  logic          unit_last;

  assign active    = (state_q == ST_SEND);
  assign advance   = active && (master_q || !enb_n_in);
  assign unit_last = (cnt_q == len_q - 1'b1) && (byte_q || phase_q);
  assign load_cfg  = (state_q == ST_IDLE) && start_ok;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (load_cfg) begin
      state_d = ST_SEND;
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (advance) begin
      if (unit_last) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
        phase_d = 1'b0;
      end else if (byte_q || phase_q) begin
        cnt_d   = cnt_q + 1'b1;
        phase_d = 1'b0;
      end else begin
        phase_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      byte_q   <= 1'b1;
      master_q <= 1'b1;
    end else if (load_cfg) begin
      len_q    <= cfg_cell_len;
      byte_q   <= cfg_byte_mode;
      master_q <= cfg_master;
    end
  end

  assign first_unit = active && (cnt_q == '0) && !phase_q;
  assign hi_phase   = phase_q;
  assign byte_mode  = byte_q;
  assign master     = master_q;
  assign pop        = advance && (byte_q || phase_q);

  // R2: a cell only begins after cell-available and a complete cell were seen
  a_r2_start_needs_clav: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(start_ok));

  // R3: a master cell runs without pauses until its last unit
  a_r3_master_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (active && master_q && !unit_last) |=> active);

  // R9: the port is idle in the cycle after a cell's last unit
  a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && unit_last) |=> !active);

  // R8: a slave keeps its position while the external enable is high
  a_r8_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !master_q && enb_n_in) |=> ($stable(cnt_q) && $stable(phase_q) && active));
endmodule

// File: rtl/cop_fmt.sv
module cop_fmt
  import cop_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int NW = NIB_W
) (
  input  logic          active,
  input  logic          first_unit,
  input  logic          hi_phase,
  input  logic          byte_mode,
  input  logic          master,
  input  logic [WW-1:0] word,
  output logic [WW-1:0] dout,
  output logic          soc,
  output logic          enb_n_out
);
  localparam int SIDE_BIT = WW - 1;
  localparam int SLV_BIT  = WW - 2;

  logic [NW-1:0] nib;
  logic [WW-1:0] nib_bus;

  assign nib = hi_phase ? word[2*NW-1:NW] : word[NW-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < WW; gi++) begin : g_lane
      if (gi < NW) begin : g_nib
        assign nib_bus[gi] = nib[gi];
      end else if (gi == SIDE_BIT) begin : g_side
        assign nib_bus[gi] = word[SIDE_BIT];
      end else if (gi == SLV_BIT) begin : g_slv
        assign nib_bus[gi] = master;
      end else begin : g_unused
        assign nib_bus[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    dout      = '0;
    soc       = 1'b0;
    enb_n_out = 1'b1;
    if (active) begin
      dout      = byte_mode ? word : nib_bus;
      soc       = first_unit;
      enb_n_out = !master;
    end
  end
endmodule

// File: rtl/cell_out_port.sv
module cell_out_port
  import cop_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int NW = NIB_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_byte_mode,
  input  logic          cfg_master,
  input  logic [LW-1:0] cfg_cell_len,
  input  logic          q_cell_ready,
  input  logic [WW-1:0] q_rd_data,
  output logic          q_rd_en,
  input  logic          dn_clav,
  input  logic          enb_n_in,
  output logic          enb_n_out,
  output logic          soc,
  output logic [WW-1:0] dout
);
  logic rst_i_n;
  logic active, first_unit, hi_phase, byte_mode, master, pop;

  cop_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cop_seq #(.LW(LW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .start_ok      (dn_clav && q_cell_ready),
    .cfg_byte_mode (cfg_byte_mode),
    .cfg_master    (cfg_master),
    .cfg_cell_len  (cfg_cell_len),
    .enb_n_in      (enb_n_in),
    .active        (active),
    .first_unit    (first_unit),
    .hi_phase      (hi_phase),
    .byte_mode     (byte_mode),
    .master        (master),
    .pop           (pop)
  );

  cop_fmt #(.WW(WW), .NW(NW)) u_fmt (
    .active     (active),
    .first_unit (first_unit),
    .hi_phase   (hi_phase),
    .byte_mode  (byte_mode),
    .master     (master),
    .word       (q_rd_data),
    .dout       (dout),
    .soc        (soc),
    .enb_n_out  (enb_n_out)
  );

  assign q_rd_en = pop;

  // R4: start-of-cell drops once the first unit has gone out
  a_r4_soc_once: assert property (@(posedge clk) disable iff (!rst_i_n)
    (soc && (master || !enb_n_in)) |=> !soc);

  // R6: the side bit stays fixed across the two nibbles of a word
  a_r6_side_held: assert property (@(posedge clk) disable iff (!rst_i_n)
    (active && !byte_mode && hi_phase) |-> (dout[WW-1] == $past(dout[WW-1])));

  // R7: a master in nibble mode raises the slave enable line on each transfer
  a_r7_slave_line: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!enb_n_out && !byte_mode) |-> dout[WW-2]);

  // R8: the enable output is never driven low in slave role
  a_r8_slave_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    (active && !master) |-> enb_n_out);
endmodule

// File: tb/cell_out_port_test.sv
module cell_out_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_byte_mode, cfg_master;
  logic [7:0] cfg_cell_len;
  logic       q_cell_ready;
  logic [8:0] q_rd_data;
  logic       q_rd_en;
  logic       dn_clav, enb_n_in, enb_n_out, soc;
  logic [8:0] dout;

  logic [8:0] mem [0:255];
  logic [7:0] wr_ptr, rd_ptr;
  logic [9:0] exp_q [$];
  int checks = 0, fails = 0;
  int units_per_cell = 0, left = 0;
  logic slave_go = 1'b0;
  logic prev_xfer = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_out_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_byte_mode(cfg_byte_mode), .cfg_master(cfg_master),
    .cfg_cell_len(cfg_cell_len), .q_cell_ready(q_cell_ready), .q_rd_data(q_rd_data),
    .q_rd_en(q_rd_en), .dn_clav(dn_clav), .enb_n_in(enb_n_in), .enb_n_out(enb_n_out),
    .soc(soc), .dout(dout)
  );

  assign q_rd_data    = mem[rd_ptr];
  assign q_cell_ready = (8'(wr_ptr - rd_ptr) >= cfg_cell_len);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) rd_ptr <= '0;
    else if (q_rd_en) rd_ptr <= rd_ptr + 8'd1;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: write one word into the queue model and push its expected transfers
  task automatic push_word(input logic [8:0] w, input bit first, input bit bmode, input bit mst);
    mem[wr_ptr] = w;
    wr_ptr = wr_ptr + 8'd1;
    if (bmode) exp_q.push_back({first, w});
    else begin
      exp_q.push_back({first, w[8], mst, 3'b000, w[3:0]});
      exp_q.push_back({1'b0,  w[8], mst, 3'b000, w[7:4]});
    end
  endtask

  task automatic push_cell(input int len, input logic [8:0] base, input bit bmode, input bit mst);
    for (int i = 0; i < len; i++) push_word(base + 9'(i * 37), (i == 0), bmode, mst);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin cyc(1); guard++; end
    chk(exp_q.size() == 0, tag, 16'(exp_q.size()), 16'd0);
    cyc(3);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      logic xfer;
      logic [9:0] e;
      xfer = cfg_master ? !enb_n_out : (slave_go && !enb_n_in);
      if (!cfg_master && slave_go && enb_n_in && exp_q.size() != 0) begin
        chk({soc, dout} == exp_q[0], "R8 hold", 16'({soc, dout}), 16'(exp_q[0]));
      end
      if (!cfg_master) chk(enb_n_out == 1'b1, "R8 enb_n_out", 16'(enb_n_out), 16'd1);
      if (xfer) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected transfer", 16'({soc, dout}), 16'd0);
        else begin
          e = exp_q.pop_front();
          chk({soc, dout} == e, "R4/R5/R6/R7 data", 16'({soc, dout}), 16'(e));
        end
        if (soc) begin
          chk(!prev_xfer, "R9 idle gap", 16'(prev_xfer), 16'd0);
          left = units_per_cell - 1;
        end else if (left > 0) left--;
      end else if (cfg_master && left > 0) begin
        chk(1'b0, "R3 gap inside cell", 16'(left), 16'd0);
        left = 0;
      end
      prev_xfer = xfer;
    end
  end

  initial begin
    int cyc_cnt = 0;
    while (cyc_cnt < 100000) begin @(posedge clk); cyc_cnt++; end
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_ptr = '0;
    cfg_byte_mode = 1'b1; cfg_master = 1'b1; cfg_cell_len = 8'd4;
    dn_clav = 1'b0; enb_n_in = 1'b1;
    cyc(3);
    // R1: reset state
    chk(enb_n_out == 1'b1, "R1 enb_n_out", 16'(enb_n_out), 16'd1);
    chk(soc == 1'b0 && dout == '0, "R1 soc/dout", 16'({soc, dout}), 16'd0);
    chk(q_rd_en == 1'b0, "R1 q_rd_en", 16'(q_rd_en), 16'd0);
    rst_n = 1'b1;
    cyc(4);
    chk(enb_n_out == 1'b1 && dout == '0, "R1 after reset", 16'({enb_n_out, dout}), 16'h200);

    // R2: full cell but no cell-available
    units_per_cell = 4;
    push_cell(4, 9'h015, 1'b1, 1'b1);
    cyc(6);
    chk(enb_n_out == 1'b1 && rd_ptr == 8'd0, "R2 clav low", 16'({enb_n_out, rd_ptr}), 16'h100);
    dn_clav = 1'b1;
    drain("R5 byte cell drained");

    // R2: cell-available but only part of a cell stored
    push_word(9'h1A3, 1'b1, 1'b1, 1'b1);
    push_word(9'h04C, 1'b0, 1'b1, 1'b1);
    cyc(6);
    chk(enb_n_out == 1'b1 && rd_ptr == 8'd4, "R2 partial cell", 16'({enb_n_out, rd_ptr}), 16'h104);
    push_word(9'h1F0, 1'b0, 1'b1, 1'b1);
    push_word(9'h00F, 1'b0, 1'b1, 1'b1);
    drain("R2 partial then complete");

    // R6/R7: master nibble mode
    dn_clav = 1'b0; cfg_byte_mode = 1'b0; cfg_cell_len = 8'd3; units_per_cell = 6;
    push_cell(3, 9'h1C5, 1'b0, 1'b1);
    cyc(1);
    dn_clav = 1'b1;
    drain("R6 nibble cell drained");

    // R9: two cells queued back to back, single-word length edge
    dn_clav = 1'b0; cfg_byte_mode = 1'b1; cfg_cell_len = 8'd1; units_per_cell = 1;
    push_cell(1, 9'h111, 1'b1, 1'b1);
    push_cell(1, 9'h0EE, 1'b1, 1'b1);
    push_cell(1, 9'h155, 1'b1, 1'b1);
    cyc(1);
    dn_clav = 1'b1;
    drain("R9 back to back");

    // R10: configuration changed mid-cell
    dn_clav = 1'b0; cfg_cell_len = 8'd5; units_per_cell = 5;
    push_cell(5, 9'h0A0, 1'b1, 1'b1);
    cyc(1);
    dn_clav = 1'b1;
    cyc(3);
    cfg_byte_mode = 1'b0; cfg_cell_len = 8'd2; cfg_master = 1'b1;
    drain("R10 latched config");
    dn_clav = 1'b0; cfg_byte_mode = 1'b1; cfg_cell_len = 8'd5;
    cyc(2);

    // R8: slave nibble mode with an irregular external enable
    cfg_master = 1'b0; cfg_byte_mode = 1'b0; cfg_cell_len = 8'd2; units_per_cell = 4;
    push_cell(2, 9'h13C, 1'b0, 1'b0);
    dn_clav = 1'b1;
    cyc(2);
    dn_clav = 1'b0;
    slave_go = 1'b1;
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) begin
      enb_n_in = (i % 3 == 1);
      cyc(1);
    end
    enb_n_in = 1'b1;
    chk(exp_q.size() == 0, "R8 slave nibble drained", 16'(exp_q.size()), 16'd0);
    slave_go = 1'b0;
    cyc(3);

    // R8: slave byte mode
    cfg_byte_mode = 1'b1; cfg_cell_len = 8'd3; units_per_cell = 3;
    push_cell(3, 9'h0C3, 1'b1, 1'b0);
    dn_clav = 1'b1;
    cyc(2);
    dn_clav = 1'b0;
    slave_go = 1'b1;
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) begin
      enb_n_in = (i % 2 == 1);
      cyc(1);
    end
    enb_n_in = 1'b1;
    chk(exp_q.size() == 0, "R8 slave byte drained", 16'(exp_q.size()), 16'd0);
    slave_go = 1'b0;
    cyc(3);
    chk(rd_ptr == wr_ptr, "R5 all words popped", 16'(rd_ptr), 16'(wr_ptr));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule